// File: doc/BRIEF.md
# Self-Timed Power-Up Reset Source

This block gives a device with no power-on reset pin a clean synchronous reset for its user logic. A free-running counter starts from whatever its flip-flops hold after configuration. An optional asynchronous reset can instead load it with zero. The counter advances by one on each clock until it reaches a fixed terminal pattern, and then it freezes. While the count is short of that pattern the synchronous reset output stays high. It drops on the next clock edge and stays low from then on.

The terminal pattern alternates ones and zeros across the counter width. It is never all zeros or all ones, because those are the most likely power-up states of a register that nothing has initialised. The generated reset never clears the counter that times it. A start value of all ones therefore wraps through zero and still completes a single count. The block has no data path, so both outputs are plain level signals.

Top module: `por_gen`

## Requirements
- R1: While the count differs from the terminal pattern, the counter advances by one on each rising clock edge and wraps from all ones to zero.
- R2: The terminal pattern has bit 0 equal to 0, and the bits alternate upward from there, so bit i is 1 exactly when i is odd (0xAA for 8 bits, 0xAAAA for 16 bits).
- R3: Once the count equals the terminal pattern, it holds that value on every later edge until the asynchronous reset is asserted.
- R4: `srst_o` is high at power-up and on every edge where the count was not yet at the pattern. It falls on the clock edge after the count first equals the pattern. From a start value V this is edge number ((PATTERN - V) mod 2^W) + 1.
- R5: `done_o` is always the complement of `srst_o`. Once it goes high it stays high until the asynchronous reset is asserted.
- R6: Driving `arst_ni` low at once zeroes the counter, raises `srst_o` and clears `done_o`, with no clock edge needed. After release the count runs once from zero, and `srst_o` falls PATTERN + 1 edges after release.
- R7: `srst_o` never clears the counter. A start value of all ones wraps through zero and completes its count.
- R8: With `arst_ni` held high from time zero, the block reaches its terminal state from any start value: all zeros, all ones, an arbitrary value, or the pattern itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| arst_ni | input | 1 | Optional asynchronous reset, active low; tie high when unused |
| srst_o | output | 1 | Synchronous reset for user logic, active high |
| done_o | output | 1 | High once the power-up count has finished |

## Verification
The assertions check four things on every cycle: the single-step increment while counting, the freeze at the terminal pattern, the complement relation between the two outputs, and that the done flag, once high, stays high. Only the bench scenarios can show the exact deassertion edge for each start value, including the wrap from all ones and a start value already equal to the pattern. The same holds for the immediate effect of the asynchronous reset and the full second count that follows its release.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned MAX_W = 64;

  // Alternating pattern: bit i set when i is odd, bit 0 clear.
  function automatic logic [MAX_W-1:0] alt_pattern(int unsigned width);
    logic [MAX_W-1:0] p;
    p = '0;
    for (int unsigned i = 0; i < MAX_W; i++) begin
      if (i < width) p[i] = i[0];
    end
    return p;
  endfunction
endpackage

// File: rtl/por_count.sv
module por_count #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic         hold_i,
  output logic [W-1:0] cnt_o
);
  // Initial value models the configured state of the flip-flops.
  logic [W-1:0] cnt_q = INIT_VAL;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    cnt_q <= '0;
    else if (!hold_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/por_cmp.sv
module por_cmp #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TERM = '0
) (
  input  logic [W-1:0] cnt_i,
  output logic         hit_o
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = (cnt_i[i] == TERM[i]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/por_flag.sv
module por_flag (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic hit_i,
  output logic srst_o,
  output logic done_o
);
  logic srst_q = 1'b1;
  logic done_q = 1'b0;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      srst_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      srst_q <= ~hit_i;
      done_q <= hit_i;
    end
  end

  assign srst_o = srst_q;
  assign done_o = done_q;
endmodule

// File: rtl/por_gen.sv
module por_gen #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_o,
  output logic done_o
);
  import por_pkg::*;

  localparam logic [MAX_W-1:0] TERM_FULL = alt_pattern(W);
  localparam logic [W-1:0]     TERM      = TERM_FULL[W-1:0];

  logic [W-1:0] cnt_w;
  logic         hit_w;

  por_count #(.W(W), .INIT_VAL(INIT_VAL)) u_count (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .hold_i (hit_w),
    .cnt_o  (cnt_w)
  );

  por_cmp #(.W(W), .TERM(TERM)) u_cmp (
    .cnt_i(cnt_w),
    .hit_o(hit_w)
  );

  por_flag u_flag (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .hit_i  (hit_w),
    .srst_o (srst_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/por_gen_chk.sv
module por_gen_chk #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TERM = '0
) (
  input logic         clk_i,
  input logic         arst_ni,
  input logic [W-1:0] cnt,
  input logic         srst_o,
  input logic         done_o
);
  // R1: single increment while short of the pattern
  a_r1_step: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt != TERM) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R3: frozen at the pattern
  a_r3_freeze: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt == TERM) |=> (cnt == TERM));

  // R4: reset still high on the edge after an unfinished count
  a_r4_srst_held: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt != TERM) |=> srst_o);

  // R5: outputs complementary, done sticky
  a_r5_complement: assert property (@(posedge clk_i) disable iff (!arst_ni)
    srst_o != done_o);
  a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (!arst_ni)
    done_o |=> done_o);
endmodule

bind por_gen por_gen_chk #(.W(W), .TERM(TERM)) u_chk (
  .clk_i  (clk_i),
  .arst_ni(arst_ni),
  .cnt    (cnt_w),
  .srst_o (srst_o),
  .done_o (done_o)
);

// File: tb/por_gen_tb_top.sv
`timescale 1ns/1ps
module por_gen_tb_top;
  localparam int NS = 4;
  localparam int SW = 8;
  localparam logic [SW-1:0] INIT_TAB [NS] = '{8'h00, 8'hFF, 8'h5C, 8'hAA};
  // expected falling edge of srst: ((0xAA - init) mod 256) + 1
  localparam int EXP_FALL [NS] = '{171, 172, 79, 1};
  localparam int BIG_FALL = 16'hAAAA + 1;

  logic clk = 1'b0;
  logic arst_n = 1'b1;
  logic [NS-1:0] srst_v, done_v;
  logic srst_big, done_big;
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(NS/2) clk = ~clk;

  for (genvar g = 0; g < NS; g++) begin : g_small
    por_gen #(.W(SW), .INIT_VAL(INIT_TAB[g])) u_small (
      .clk_i(clk), .arst_ni(1'b1), .srst_o(srst_v[g]), .done_o(done_v[g]));
  end

  por_gen dut_i (.clk_i(clk), .arst_ni(arst_n), .srst_o(srst_big), .done_o(done_big));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(NS * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int fall [NS];
    bit rea [NS];
    bit cbad [NS];
    int n;
    for (int g = 0; g < NS; g++) begin fall[g] = 0; rea[g] = 0; cbad[g] = 0; end
    #1;
    // R4 R5: power-up state
    for (int g = 0; g < NS; g++) begin
      check(srst_v[g] == 1'b1, "R4 powerup srst", int'(srst_v[g]), 1);
      check(done_v[g] == 1'b0, "R5 powerup done", int'(done_v[g]), 0);
    end
    check(srst_big == 1'b1, "R4 powerup srst big", int'(srst_big), 1);
    n = 0;
    // R8: table walk, arst tied high
    for (int e = 1; e <= 200; e++) begin
      @(posedge clk); #1;
      n = e;
      for (int g = 0; g < NS; g++) begin
        if (fall[g] == 0 && !srst_v[g]) fall[g] = e;
        if (fall[g] != 0 && srst_v[g]) rea[g] = 1;
        if (srst_v[g] == done_v[g]) cbad[g] = 1;
      end
    end
    for (int g = 0; g < NS; g++) begin
      check(fall[g] == EXP_FALL[g], "R4 R7 R8 fall edge", fall[g], EXP_FALL[g]);
      check(!rea[g], "R3 R5 no reassert", int'(rea[g]), 0);
      check(!cbad[g], "R5 complement", int'(cbad[g]), 0);
    end
    // R1 R2: 16-bit default from zero, fall at 0xAAAA+1
    while (srst_big && n < 60000) begin @(posedge clk); #1; n++; end
    check(n == BIG_FALL, "R1 R2 big fall edge", n, BIG_FALL);
    repeat (10) @(posedge clk);
    #1;
    check(done_big == 1'b1 && srst_big == 1'b0, "R3 R5 held done", int'(done_big), 1);
    // R6: async assert takes effect without a clock edge
    arst_n = 1'b0;
    #0.5;
    check(srst_big == 1'b1, "R6 async srst", int'(srst_big), 1);
    check(done_big == 1'b0, "R6 async done", int'(done_big), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    arst_n = 1'b1;
    n = 0;
    while (srst_big && n < 60000) begin @(posedge clk); #1; n++; end
    check(n == BIG_FALL, "R6 recount fall edge", n, BIG_FALL);
    check(done_big == 1'b1, "R6 done after recount", int'(done_big), 1);
    finish_run();
  end
endmodule